// File: doc/BRIEF.md
# Time-over-threshold strip hit recorder

This block serves a group of silicon-strip channels. Each channel delivers two discriminator levels: a low comparator that measures pulse width and a high comparator that qualifies a hit. On every pulse of a slow sample strobe (one 400 ns timestamp period), the block samples both comparator buses. For each channel, a rising low comparator opens a window and a falling low comparator closes it. The block stamps both edges with an event-time counter that runs across the beam spill.

A window is kept only when a high comparator fires while the window is open, either on the channel itself or on a channel directly beside it in the group. The neighbour rule keeps the small flanking strips that a centroid calculation needs. A kept window produces two tagged words, one for the opening edge and one for the closing edge, in a shared local FIFO that downstream logic drains. A window still open when the spill ends is closed with a forced trailing record. A full FIFO drops words and raises a sticky overflow flag.

Top module: `tot_hit_recorder`

## Requirements
- R1: `event_time` is 0 after reset. A strobe with `spill_start` high loads 0. Every other strobe adds 1, and the counter holds at 2^TS_W-1 (1023 by default) instead of wrapping.
- R2: Each strobe is stamped with the `event_time` value present before that strobe. The leading word carries the stamp of the first strobe that sees the low comparator high. The trailing word carries the stamp of the first strobe that sees it low again.
- R3: A window is kept when the channel's own high comparator is high on any strobe where its low comparator is high inside the window.
- R4: A window is also kept when the high comparator of channel i-1 or i+1 is high on such a strobe. Neighbours are taken within the group only: channel 0 and channel NCH-1 are not neighbours.
- R5: A window with no qualifying high comparator writes nothing. A high comparator on a channel with no open window produces no record.
- R6: Word layout, with default width 13: bits [12:11] are the channel index, bit [10] is 1 for a leading edge and 0 for a trailing edge, and bits [9:0] are the timestamp.
- R7: A kept window writes its leading word first and its trailing word second. Windows closing on the same strobe are written in ascending channel order.
- R8: A strobe with `spill_end` high closes every window whose low comparator is high. A kept window gets a trailing word stamped with that strobe. No new leading edge is seen until the low comparator has fallen.
- R9: A word arriving while the FIFO holds DEPTH (8) words is dropped and sets `overflow`. `overflow` stays set until a strobe with `spill_start`. Exactly DEPTH words do not set it.
- R10: The FIFO reads show-ahead. `rd_valid` is high while words are stored, `rd_data` is the oldest word, and `rd_en` removes it. After reset the FIFO is empty and `overflow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle sample strobe, one per timestamp period |
| spill_start | input | 1 | Spill begins; acts on a strobe |
| spill_end | input | 1 | Spill ends; acts on a strobe |
| lo_cmp | input | NCH | Low (readout) comparator levels |
| hi_cmp | input | NCH | High (qualifying) comparator levels |
| rd_en | input | 1 | Pop the oldest FIFO word |
| rd_valid | output | 1 | FIFO holds at least one word |
| rd_data | output | CH_W+1+TS_W | Oldest FIFO word |
| overflow | output | 1 | Sticky: a word was dropped |
| event_time | output | TS_W | Current event-time count |

## Verification
The assertions assume that all inputs are synchronous to `clk`. They also assume that consecutive strobes are at least 2*NCH+1 cycles apart, so the pending words of one strobe are written before the next strobe can post more. The bench changes inputs only on falling edges and spaces strobes 12 cycles apart whenever a window can close. Strobes that cannot close a window are spaced 2 cycles apart. The bench pulses `rd_en` only while no window is being written.

// File: rtl/tot_pkg.sv
package tot_pkg;
  typedef enum logic {
    EDGE_TRAIL = 1'b0,
    EDGE_LEAD  = 1'b1
  } edge_t;
endpackage

// File: rtl/tot_event_timer.sv
module tot_event_timer #(
  parameter int TS_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            spill_start,
  output logic [TS_W-1:0] count
);
  localparam logic [TS_W-1:0] TS_MAX = {TS_W{1'b1}};

  function automatic logic [TS_W-1:0] sat_inc(input logic [TS_W-1:0] v);
    return (v == TS_MAX) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)                count <= '0;
    else if (tick && spill_start) count <= '0;
    else if (tick)             count <= sat_inc(count);
  end

  a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tick && spill_start |=> count == '0);
  a_r1_hold_max: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !spill_start && count == TS_MAX |=> count == TS_MAX);
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !spill_start && count != TS_MAX |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/tot_strip_window.sv
module tot_strip_window #(
  parameter int TS_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            spill_start,
  input  logic            spill_end,
  input  logic            lo,
  input  logic            nbr_hi,
  input  logic [TS_W-1:0] stamp,
  input  logic            clr_lead,
  input  logic            clr_trail,
  output logic            lead_pend,
  output logic            trail_pend,
  output logic [TS_W-1:0] lead_ts,
  output logic [TS_W-1:0] trail_ts
);
  logic lo_prev, open_q, acc_q;
  logic lead, active, acc_n, close, commit;

  always_comb begin
    lead   = lo & ~lo_prev;
    active = lo & (open_q | lead);
    acc_n  = (lead ? 1'b0 : acc_q) | (active & nbr_hi);
    close  = (open_q & ~lo) | (active & spill_end);
    commit = tick & ~spill_start & close & acc_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_prev    <= 1'b0;
      open_q     <= 1'b0;
      acc_q      <= 1'b0;
      lead_ts    <= '0;
      trail_ts   <= '0;
      lead_pend  <= 1'b0;
      trail_pend <= 1'b0;
    end else begin
      if (tick) begin
        lo_prev <= lo;
        if (spill_start) begin
          open_q <= 1'b0;
          acc_q  <= 1'b0;
        end else begin
          if (lead) lead_ts <= stamp;
          if (close) begin
            open_q <= 1'b0;
            acc_q  <= 1'b0;
          end else if (active) begin
            open_q <= 1'b1;
            acc_q  <= acc_n;
          end
          if (close && acc_n) trail_ts <= stamp;
        end
      end
      if (commit)          lead_pend <= 1'b1;
      else if (clr_lead)   lead_pend <= 1'b0;
      if (commit)          trail_pend <= 1'b1;
      else if (clr_trail)  trail_pend <= 1'b0;
    end
  end

  // R7: the leading word always leaves before its trailing partner
  a_r7_lead_before_trail: assert property (@(posedge clk) disable iff (!rst_n)
    lead_pend |-> trail_pend);
  a_r8_end_closes: assert property (@(posedge clk) disable iff (!rst_n)
    tick && spill_end && !spill_start |=> !open_q);
  a_r5_no_spurious_post: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(trail_ts));
endmodule

// File: rtl/tot_local_fifo.sv
module tot_local_fifo #(
  parameter int W     = 13,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  input  logic         ovf_clr,
  output logic [W-1:0] rdata,
  output logic         not_empty,
  output logic         overflow
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   cnt;
  logic full, push, pop;

  assign full      = (cnt == (AW+1)'(DEPTH));
  assign not_empty = (cnt != '0);
  assign push      = wr && !full;
  assign pop       = rd && not_empty;
  assign rdata     = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      cnt      <= '0;
      overflow <= 1'b0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      cnt <= cnt + (push ? 1'b1 : 1'b0) - (pop ? 1'b1 : 1'b0);
      if (ovf_clr)        overflow <= 1'b0;
      else if (wr && full) overflow <= 1'b1;
    end
  end

  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(DEPTH));
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !ovf_clr |=> overflow);
  a_r9_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    wr && full && !ovf_clr |=> overflow);
endmodule

// File: rtl/tot_hit_recorder.sv
module tot_hit_recorder #(
  parameter int NCH   = 4,
  parameter int TS_W  = 10,
  parameter int DEPTH = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick,
  input  logic                          spill_start,
  input  logic                          spill_end,
  input  logic [NCH-1:0]                lo_cmp,
  input  logic [NCH-1:0]                hi_cmp,
  input  logic                          rd_en,
  output logic                          rd_valid,
  output logic [$clog2(NCH)+TS_W:0]     rd_data,
  output logic                          overflow,
  output logic [TS_W-1:0]               event_time
);
  import tot_pkg::*;

  localparam int CH_W   = $clog2(NCH);
  localparam int WORD_W = CH_W + 1 + TS_W;

  function automatic logic [WORD_W-1:0] pack_word(input logic [CH_W-1:0] ch,
                                                  input edge_t e,
                                                  input logic [TS_W-1:0] ts);
    return {ch, e, ts};
  endfunction

  logic [NCH-1:0]  nbr_hi, lead_pend, trail_pend, clr_lead, clr_trail;
  logic [TS_W-1:0] lead_ts [NCH];
  logic [TS_W-1:0] trail_ts [NCH];
  logic [CH_W-1:0] sel;
  logic            any_pend;
  logic            wr_valid;
  logic [WORD_W-1:0] wr_word;

  tot_event_timer #(.TS_W(TS_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .spill_start(spill_start),
    .count(event_time)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    if (i == 0) begin : g_first
      assign nbr_hi[i] = hi_cmp[i] | hi_cmp[i+1];
    end else if (i == NCH-1) begin : g_last
      assign nbr_hi[i] = hi_cmp[i] | hi_cmp[i-1];
    end else begin : g_mid
      assign nbr_hi[i] = hi_cmp[i] | hi_cmp[i-1] | hi_cmp[i+1];
    end

    tot_strip_window #(.TS_W(TS_W)) u_win (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .spill_start(spill_start), .spill_end(spill_end),
      .lo(lo_cmp[i]), .nbr_hi(nbr_hi[i]), .stamp(event_time),
      .clr_lead(clr_lead[i]), .clr_trail(clr_trail[i]),
      .lead_pend(lead_pend[i]), .trail_pend(trail_pend[i]),
      .lead_ts(lead_ts[i]), .trail_ts(trail_ts[i])
    );
  end

  // lowest-index channel with pending words wins the FIFO write port
  always_comb begin
    sel      = '0;
    any_pend = 1'b0;
    for (int i = NCH-1; i >= 0; i--) begin
      if (lead_pend[i] || trail_pend[i]) begin
        sel      = CH_W'(i);
        any_pend = 1'b1;
      end
    end
    clr_lead  = '0;
    clr_trail = '0;
    if (any_pend) begin
      if (lead_pend[sel]) clr_lead[sel]  = 1'b1;
      else                clr_trail[sel] = 1'b1;
    end
    wr_valid = any_pend;
    wr_word  = lead_pend[sel] ? pack_word(sel, EDGE_LEAD,  lead_ts[sel])
                              : pack_word(sel, EDGE_TRAIL, trail_ts[sel]);
  end

  tot_local_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr(wr_valid), .wdata(wr_word),
    .rd(rd_en), .ovf_clr(tick && spill_start),
    .rdata(rd_data), .not_empty(rd_valid), .overflow(overflow)
  );

  a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_lead | clr_trail));
  a_r7_drain_progress: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !tick |=> $countones(lead_pend | trail_pend) <= $countones($past(lead_pend | trail_pend)));
endmodule

// File: tb/tot_hit_recorder_test.sv
module tot_hit_recorder_test;
  localparam int NCH = 4, TS_W = 10, DEPTH = 8;
  localparam int TS_MAX = 1023;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, spill_start = 1'b0, spill_end = 1'b0;
  logic [NCH-1:0] lo_cmp = '0, hi_cmp = '0;
  logic rd_en = 1'b0;
  logic rd_valid, overflow;
  logic [12:0] rd_data;
  logic [TS_W-1:0] event_time;

  int checks = 0, errors = 0;
  int et = 0, last_stamp = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tot_hit_recorder #(.NCH(NCH), .TS_W(TS_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .spill_start(spill_start),
    .spill_end(spill_end), .lo_cmp(lo_cmp), .hi_cmp(hi_cmp), .rd_en(rd_en),
    .rd_valid(rd_valid), .rd_data(rd_data), .overflow(overflow),
    .event_time(event_time)
  );

  function automatic int word(input int ch, input int lead, input int ts);
    return ch * 2048 + lead * 1024 + ts;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [3:0] lo, input logic [3:0] hi,
                        input bit st, input bit en, input int gap);
    @(negedge clk);
    lo_cmp = lo; hi_cmp = hi; spill_start = st; spill_end = en; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0; spill_start = 1'b0; spill_end = 1'b0;
    last_stamp = et;
    if (st) et = 0;
    else if (et < TS_MAX) et = et + 1;
    repeat (gap) @(negedge clk);
  endtask

  task automatic pop_exp(input string req, input int exp);
    chk({req, " valid"}, int'(rd_valid), 1);
    chk({req, " data"}, int'(rd_data), exp);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 reset empty", int'(rd_valid), 0);
    chk("R10 reset overflow", int'(overflow), 0);
    chk("R1 reset time", int'(event_time), 0);
  endtask

  task automatic t_timer;
    strobe(4'h0, 4'h0, 1, 0, 2);
    chk("R1 start loads zero", int'(event_time), 0);
    for (int k = 0; k < 5; k++) strobe(4'h0, 4'h0, 0, 0, 2);
    chk("R1 counts strobes", int'(event_time), 5);
  endtask

  task automatic t_own;
    int s1, s3;
    strobe(4'b0010, 4'b0000, 0, 0, 11); s1 = last_stamp;
    strobe(4'b0010, 4'b0010, 0, 0, 11);
    strobe(4'b0000, 4'b0000, 0, 0, 11); s3 = last_stamp;
    pop_exp("R2 R3 R6 own lead", word(1, 1, s1));
    pop_exp("R2 R3 R6 own trail", word(1, 0, s3));
    chk("R3 drained", int'(rd_valid), 0);
  endtask

  task automatic t_nbr;
    int s1, s3;
    strobe(4'b0111, 4'b0000, 0, 0, 11); s1 = last_stamp;
    strobe(4'b0111, 4'b0010, 0, 0, 11);
    strobe(4'b0000, 4'b0000, 0, 0, 11); s3 = last_stamp;
    for (int c = 0; c < 3; c++) begin
      pop_exp("R4 R7 nbr lead", word(c, 1, s1));
      pop_exp("R4 R7 nbr trail", word(c, 0, s3));
    end
    chk("R4 no record beyond neighbour", int'(rd_valid), 0);
  endtask

  task automatic t_reject;
    strobe(4'b0001, 4'b1000, 0, 0, 11);
    strobe(4'b0000, 4'b0100, 0, 0, 11);
    strobe(4'b0100, 4'b0000, 0, 0, 11);
    strobe(4'b0000, 4'b0000, 0, 0, 11);
    chk("R5 R4 no write without qualifier or across group edge", int'(rd_valid), 0);
  endtask

  task automatic t_spill_end;
    int s1, s2;
    strobe(4'b0010, 4'b0000, 0, 0, 11); s1 = last_stamp;
    strobe(4'b0010, 4'b0010, 0, 1, 11); s2 = last_stamp;
    strobe(4'b0010, 4'b0010, 0, 0, 11);
    strobe(4'b0000, 4'b0000, 0, 0, 11);
    pop_exp("R8 lead", word(1, 1, s1));
    pop_exp("R8 forced trail", word(1, 0, s2));
    chk("R8 no reopen", int'(rd_valid), 0);
  endtask

  task automatic t_overflow;
    int s1;
    strobe(4'b1111, 4'b1111, 0, 0, 11); s1 = last_stamp;
    strobe(4'b0000, 4'b0000, 0, 0, 11);
    chk("R9 exactly full no flag", int'(overflow), 0);
    strobe(4'b0001, 4'b0001, 0, 0, 11);
    strobe(4'b0000, 4'b0000, 0, 0, 11);
    chk("R9 flag on drop", int'(overflow), 1);
    pop_exp("R9 R10 oldest kept", word(0, 1, s1));
    for (int k = 1; k < DEPTH; k++) begin
      chk("R9 stored word", int'(rd_valid), 1);
      rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    end
    chk("R9 dropped words absent", int'(rd_valid), 0);
    chk("R9 sticky", int'(overflow), 1);
    strobe(4'b0000, 4'b0000, 1, 0, 2);
    chk("R9 cleared by spill start", int'(overflow), 0);
  endtask

  task automatic t_saturate;
    strobe(4'h0, 4'h0, 1, 0, 1);
    for (int k = 0; k < 1030; k++) strobe(4'h0, 4'h0, 0, 0, 1);
    chk("R1 saturates", int'(event_time), TS_MAX);
    strobe(4'b0001, 4'b0001, 0, 0, 11);
    strobe(4'b0000, 4'b0000, 0, 0, 11);
    pop_exp("R1 R2 lead at max", word(0, 1, TS_MAX));
    pop_exp("R1 R2 trail at max", word(0, 0, TS_MAX));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_timer;
    t_own;
    t_nbr;
    t_reject;
    t_spill_end;
    t_overflow;
    t_saturate;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule